// File: doc/BRIEF.md
# Display Memory Address and Row-Scan Generator

This block produces the video memory address and the row-scan count for every character position of a raster display. A frame strobe loads a 20-bit start address into the address counter and a preset value into the row-scan counter. Character-clock enables step the address counter once per one, two or four character clocks. Each line strobe either repeats the current character row or moves on to the next one. Moving on to the next row adds the logical line width to a row base register. The width is scaled by two, four or eight.

The counter is mapped to the memory address output in one of three ways: it is passed straight through, rotated by one bit for word addressing, or rotated by two bits for doubleword addressing. While the display is active, row-scan bits can then replace two address bits, so that older interleaved bank layouts can be emulated. A line-compare value gives a split screen: on the line where the external line number matches it, the address and the row scan both restart from zero. The timing generator that drives it supplies the strobes, the display-active flag and the current line number.

Top module: `vidaddr_gen`

## Requirements
- R1: A frame strobe loads the address counter and the row base from `start_addr`, and loads the row scan from `preset_row`. Both results appear one clock after the strobe.
- R2: A line strobe that does not repeat a line advances the row scan by one. When the row scan equals `max_scan`, it instead wraps to 0 and the row base grows by the pitch. The address counter restarts from the new row base either way.
- R3: With `dbl_scan` = 1, every line strobe after a frame strobe, split or new row first repeats the line: the row scan is held and the address counter restarts from the unchanged row base. The next line strobe then advances as in R2.
- R4: The pitch is `line_offset` times 2 when `pitch_sel` = 0, times 4 when it is 1, and times 8 when it is 2 or 3. Sums wrap modulo 2^20.
- R5: The address counter increments on a character-clock enable as follows. With `cnt_by4` = 1 it steps on every fourth enable. With only `cnt_by2` = 1 it steps on every second enable. With neither set it steps on every enable. In all cases it is the last enable of each group that steps, counting from the most recent frame or line strobe. Without an enable or strobe, the counter and the row scan hold.
- R6: With `map_mode` = 1 (word), output bit i+1 is counter bit i. Output bit 0 is counter bit 15 when `wrap_hi` = 1 and counter bit 13 when `wrap_hi` = 0.
- R7: With `map_mode` = 2 or 3 (doubleword), output bit i+2 is counter bit i, and output bits 1:0 are counter bits 19:18. With `map_mode` = 0 the output equals the counter.
- R8: When `disp_active` = 1, `bank13_pass` = 0 replaces output bit 13 with row-scan bit 0, and `bank14_pass` = 0 replaces output bit 14 with row-scan bit 1. When `disp_active` = 0 no bit is replaced.
- R9: A line strobe with `line_num` equal to `line_cmp` clears the address counter, the row base and the row scan to 0.
- R10: A frame strobe takes priority over a line strobe, and a line strobe takes priority over a character-clock enable in the same cycle.
- R11: After reset the memory address and the row scan are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_en | input | 1 | Character-clock enable |
| line_start | input | 1 | Start-of-scan-line strobe |
| frame_start | input | 1 | Start-of-frame strobe |
| disp_active | input | 1 | Active display period |
| line_num | input | 11 | Current scan line number |
| line_cmp | input | 11 | Split-screen line compare value |
| start_addr | input | 20 | Frame start address |
| preset_row | input | 5 | Row scan loaded at frame start |
| max_scan | input | 5 | Scan lines per character row minus 1 |
| dbl_scan | input | 1 | Show each line twice |
| line_offset | input | 10 | Logical line width |
| pitch_sel | input | 2 | Pitch scale: 0 = x2, 1 = x4, 2/3 = x8 |
| cnt_by2 | input | 1 | Step every second character clock |
| cnt_by4 | input | 1 | Step every fourth character clock |
| map_mode | input | 2 | 0 = byte, 1 = word, 2/3 = doubleword mapping |
| wrap_hi | input | 1 | Word mode: counter bit 15 (1) or 13 (0) to output bit 0 |
| bank13_pass | input | 1 | 0 = row-scan bit 0 replaces output bit 13 during display |
| bank14_pass | input | 1 | 0 = row-scan bit 1 replaces output bit 14 during display |
| mem_addr | output | 20 | Video memory address |
| row_scan | output | 5 | Row scan count within the character cell |

## Verification
Strobes and enables act at the clock edge that samples them. The new counter, base and row values therefore show on the outputs one clock later. The address mapping and the bank substitution are combinational, so changes to `map_mode`, `wrap_hi`, the bank controls or `disp_active` show within the same cycle. The bench drives inputs just after a rising edge and updates its arithmetic model at the next rising edge. It then compares both outputs one time unit later, which is well clear of either edge. Mapping-only changes are checked after a settle delay in the cycle where they are applied.

// File: rtl/vag_pkg.sv
package vag_pkg;
    // counter bits that feed output bit 0 in word mode
    localparam int WRAP_LO_BIT = 13;
    localparam int WRAP_HI_BIT = 15;
    // output bits replaced by row-scan bits during display
    localparam int BANK0_BIT   = 13;
    localparam int BANK1_BIT   = 14;

    typedef enum logic [1:0] {
        MAP_BYTE  = 2'd0,
        MAP_WORD  = 2'd1,
        MAP_DWORD = 2'd2,
        MAP_DWRD2 = 2'd3
    } map_e;
endpackage

// File: rtl/vag_step.sv
module vag_step (
    input  logic clk,
    input  logic rst_n,
    input  logic char_en,
    input  logic restart,
    input  logic by2,
    input  logic by4,
    output logic step
);
    logic [1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (by4)
            step = char_en && (div_q == 2'd3);
        else if (by2)
            step = char_en && div_q[0];
        else
            step = char_en;
        if (restart)
            div_d = '0;
        else if (char_en)
            div_d = div_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/vag_row_ctrl.sv
module vag_row_ctrl #(
    parameter int AW = 20,
    parameter int RW = 5,
    parameter int OW = 10,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_start,
    input  logic          step,
    input  logic [AW-1:0] start_addr,
    input  logic [RW-1:0] preset_row,
    input  logic [RW-1:0] max_scan,
    input  logic          dbl_scan,
    input  logic [OW-1:0] line_offset,
    input  logic [1:0]    pitch_sel,
    input  logic [LW-1:0] line_num,
    input  logic [LW-1:0] line_cmp,
    output logic [AW-1:0] cnt,
    output logic [RW-1:0] row
);
    typedef struct packed {
        logic [AW-1:0] cnt;
        logic [AW-1:0] base;
        logic [RW-1:0] row;
        logic          rep;
    } st_t;

    st_t st_d, st_q;
    logic [AW-1:0] pitch;
    logic [AW-1:0] next_base;
    logic [1:0]    shamt;

    always_comb begin
        case (pitch_sel)
            2'd0:    shamt = 2'd1;
            2'd1:    shamt = 2'd2;
            default: shamt = 2'd3;
        endcase
        pitch     = AW'(line_offset) << shamt;
        next_base = st_q.base + pitch;
        st_d      = st_q;
        if (frame_start) begin
            st_d.cnt  = start_addr;
            st_d.base = start_addr;
            st_d.row  = preset_row;
            st_d.rep  = 1'b0;
        end else if (line_start) begin
            if (line_num == line_cmp) begin
                st_d = '0;
            end else if (dbl_scan && !st_q.rep) begin
                st_d.rep = 1'b1;
                st_d.cnt = st_q.base;
            end else begin
                st_d.rep = 1'b0;
                if (st_q.row == max_scan) begin
                    st_d.row  = '0;
                    st_d.base = next_base;
                    st_d.cnt  = next_base;
                end else begin
                    st_d.row = st_q.row + 1'b1;
                    st_d.cnt = st_q.base;
                end
            end
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign row = st_q.row;
endmodule

// File: rtl/vag_addr_map.sv
module vag_addr_map
    import vag_pkg::*;
#(
    parameter int AW = 20,
    parameter int RW = 5
) (
    input  logic [AW-1:0] cnt,
    input  logic [RW-1:0] row,
    input  logic [1:0]    map_mode,
    input  logic          wrap_hi,
    input  logic          disp_active,
    input  logic          bank13_pass,
    input  logic          bank14_pass,
    output logic [AW-1:0] mem_addr
);
    logic [AW-1:0] rot;

    always_comb begin
        case (map_e'(map_mode))
            MAP_BYTE: rot = cnt;
            MAP_WORD: rot = {cnt[AW-2:0],
                             wrap_hi ? cnt[WRAP_HI_BIT] : cnt[WRAP_LO_BIT]};
            default:  rot = {cnt[AW-3:0], cnt[AW-1:AW-2]};
        endcase
        mem_addr = rot;
        if (disp_active) begin
            if (!bank13_pass) mem_addr[BANK0_BIT] = row[0];
            if (!bank14_pass) mem_addr[BANK1_BIT] = row[1];
        end
    end
endmodule

// File: rtl/vidaddr_gen.sv
module vidaddr_gen #(
    parameter int AW = 20,
    parameter int RW = 5,
    parameter int OW = 10,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_en,
    input  logic          line_start,
    input  logic          frame_start,
    input  logic          disp_active,
    input  logic [LW-1:0] line_num,
    input  logic [LW-1:0] line_cmp,
    input  logic [AW-1:0] start_addr,
    input  logic [RW-1:0] preset_row,
    input  logic [RW-1:0] max_scan,
    input  logic          dbl_scan,
    input  logic [OW-1:0] line_offset,
    input  logic [1:0]    pitch_sel,
    input  logic          cnt_by2,
    input  logic          cnt_by4,
    input  logic [1:0]    map_mode,
    input  logic          wrap_hi,
    input  logic          bank13_pass,
    input  logic          bank14_pass,
    output logic [AW-1:0] mem_addr,
    output logic [RW-1:0] row_scan
);
    logic          step_w;
    logic [AW-1:0] cnt_w;

    vag_step u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .char_en (char_en),
        .restart (frame_start | line_start),
        .by2     (cnt_by2),
        .by4     (cnt_by4),
        .step    (step_w)
    );

    vag_row_ctrl #(.AW(AW), .RW(RW), .OW(OW), .LW(LW)) u_row (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_start  (line_start),
        .step        (step_w),
        .start_addr  (start_addr),
        .preset_row  (preset_row),
        .max_scan    (max_scan),
        .dbl_scan    (dbl_scan),
        .line_offset (line_offset),
        .pitch_sel   (pitch_sel),
        .line_num    (line_num),
        .line_cmp    (line_cmp),
        .cnt         (cnt_w),
        .row         (row_scan)
    );

    vag_addr_map #(.AW(AW), .RW(RW)) u_map (
        .cnt         (cnt_w),
        .row         (row_scan),
        .map_mode    (map_mode),
        .wrap_hi     (wrap_hi),
        .disp_active (disp_active),
        .bank13_pass (bank13_pass),
        .bank14_pass (bank14_pass),
        .mem_addr    (mem_addr)
    );
endmodule

// File: rtl/vag_chk.sv
module vag_chk #(
    parameter int AW = 20,
    parameter int RW = 5,
    parameter int LW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          char_en,
    input logic          line_start,
    input logic          frame_start,
    input logic          disp_active,
    input logic [LW-1:0] line_num,
    input logic [LW-1:0] line_cmp,
    input logic [AW-1:0] start_addr,
    input logic [RW-1:0] preset_row,
    input logic [RW-1:0] max_scan,
    input logic          dbl_scan,
    input logic          cnt_by2,
    input logic          cnt_by4,
    input logic [1:0]    map_mode,
    input logic [AW-1:0] cnt,
    input logic [RW-1:0] row,
    input logic [AW-1:0] mem_addr
);
    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (cnt == $past(start_addr)) && (row == $past(preset_row))); // R1

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start && line_num != line_cmp && !dbl_scan
         && row == max_scan) |=> row == '0); // R2

    AST_SPLIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start && line_num == line_cmp)
        |=> (cnt == '0) && (row == '0)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !line_start && !char_en) |=> $stable(cnt) && $stable(row)); // R5

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && !frame_start && !line_start && !cnt_by2 && !cnt_by4)
        |=> cnt == $past(cnt) + 1'b1); // R5

    always @(negedge clk) begin
        if (rst_n && map_mode == 2'd0 && !disp_active)
            AST_BYTE_PASS: assert (mem_addr == cnt); // R7
    end
endmodule

bind vidaddr_gen vag_chk #(.AW(AW), .RW(RW), .LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_en     (char_en),
    .line_start  (line_start),
    .frame_start (frame_start),
    .disp_active (disp_active),
    .line_num    (line_num),
    .line_cmp    (line_cmp),
    .start_addr  (start_addr),
    .preset_row  (preset_row),
    .max_scan    (max_scan),
    .dbl_scan    (dbl_scan),
    .cnt_by2     (cnt_by2),
    .cnt_by4     (cnt_by4),
    .map_mode    (map_mode),
    .cnt         (cnt_w),
    .row         (row_scan),
    .mem_addr    (mem_addr)
);

// File: tb/vidaddr_gen_tb.sv
module vidaddr_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_en = 0, line_start = 0, frame_start = 0, disp_active = 0;
    logic [10:0] line_num = 0, line_cmp = 11'h7FF;
    logic [19:0] start_addr = 0;
    logic [4:0]  preset_row = 0, max_scan = 0;
    logic        dbl_scan = 0;
    logic [9:0]  line_offset = 0;
    logic [1:0]  pitch_sel = 0, map_mode = 0;
    logic        cnt_by2 = 0, cnt_by4 = 0, wrap_hi = 0;
    logic        bank13_pass = 1, bank14_pass = 1;
    logic [19:0] mem_addr;
    logic [4:0]  row_scan;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [19:0] m_cnt = 0, m_base = 0;
    logic [4:0]  m_row = 0;
    logic        m_rep = 0;
    logic [1:0]  m_div = 0;

    vidaddr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .char_en(char_en), .line_start(line_start),
        .frame_start(frame_start), .disp_active(disp_active), .line_num(line_num),
        .line_cmp(line_cmp), .start_addr(start_addr), .preset_row(preset_row),
        .max_scan(max_scan), .dbl_scan(dbl_scan), .line_offset(line_offset),
        .pitch_sel(pitch_sel), .cnt_by2(cnt_by2), .cnt_by4(cnt_by4),
        .map_mode(map_mode), .wrap_hi(wrap_hi), .bank13_pass(bank13_pass),
        .bank14_pass(bank14_pass), .mem_addr(mem_addr), .row_scan(row_scan)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [19:0] exp_map(input logic [19:0] c, input logic [4:0] r);
        logic [19:0] m;
        if (map_mode == 2'd0)      m = c;
        else if (map_mode == 2'd1) m = {c[18:0], wrap_hi ? c[15] : c[13]};
        else                       m = {c[17:0], c[19:18]};
        if (disp_active) begin
            if (!bank13_pass) m[13] = r[0];
            if (!bank14_pass) m[14] = r[1];
        end
        return m;
    endfunction

    task automatic chk(input string tag, input logic [24:0] act, input logic [24:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual addr=%h row=%0d expected addr=%h row=%0d",
                     tag, act[24:5], act[4:0], exp[24:5], exp[4:0]);
        end
    endtask

    // one clock with the given strobes; model updated per requirements
    task automatic cyc(input logic f, input logic l, input logic c, input string tag);
        logic [19:0] pitch;
        logic        stp;
        frame_start = f; line_start = l; char_en = c;
        @(posedge clk);
        pitch = 20'(line_offset) << ((pitch_sel == 0) ? 1 : (pitch_sel == 1) ? 2 : 3);
        stp = cnt_by4 ? (m_div == 2'd3) : cnt_by2 ? m_div[0] : 1'b1;
        if (f) begin
            m_cnt = start_addr; m_base = start_addr; m_row = preset_row; m_rep = 0; m_div = 0;
        end else if (l) begin
            m_div = 0;
            if (line_num == line_cmp) begin
                m_cnt = 0; m_base = 0; m_row = 0; m_rep = 0;
            end else if (dbl_scan && !m_rep) begin
                m_rep = 1; m_cnt = m_base;
            end else begin
                m_rep = 0;
                if (m_row == max_scan) begin
                    m_row = 0; m_base = m_base + pitch;
                end else m_row = m_row + 1;
                m_cnt = m_base;
            end
        end else if (c) begin
            if (stp) m_cnt = m_cnt + 1;
            m_div = m_div + 1;
        end
        #1;
        frame_start = 0; line_start = 0; char_en = 0;
        chk(tag, {mem_addr, row_scan}, {exp_map(m_cnt, m_row), m_row});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1 chk("R11 reset", {mem_addr, row_scan}, 25'd0);

        // R1 R2 R4 R5: sweep pitch scale and step mode
        for (int ps = 0; ps < 3; ps++) begin
            for (int sm = 0; sm < 4; sm++) begin
                pitch_sel = 2'(ps); cnt_by2 = sm[0]; cnt_by4 = sm[1];
                line_offset = 10'd37 + 10'(ps); start_addr = 20'h01230 + 20'(sm);
                preset_row = 5'd1; max_scan = 5'd2;
                cyc(1, 0, 0, "R1 frame load");
                for (int ln = 0; ln < 5; ln++) begin
                    cyc(0, 1, 0, "R2 R4 line advance");
                    for (int k = 0; k < 8; k++) cyc(0, 0, 1, "R5 step");
                    cyc(0, 0, 0, "R5 idle hold");
                end
            end
        end
        cnt_by2 = 0; cnt_by4 = 0;

        // R3 double scan
        dbl_scan = 1; preset_row = 0; max_scan = 1; start_addr = 20'h00400;
        line_offset = 10'd20; pitch_sel = 0;
        cyc(1, 0, 0, "R1 frame load");
        for (int ln = 0; ln < 6; ln++) begin
            cyc(0, 1, 0, "R3 double scan line");
            for (int k = 0; k < 3; k++) cyc(0, 0, 1, "R3 step");
        end
        dbl_scan = 0;

        // R6 word mapping, R7 doubleword mapping
        start_addr = 20'h08000;
        cyc(1, 0, 0, "R1 frame load");
        map_mode = 1; wrap_hi = 0; #1
        chk("R6 word wrap lo", {mem_addr, row_scan}, {20'h10000, m_row});
        wrap_hi = 1; #1
        chk("R6 word wrap hi", {mem_addr, row_scan}, {20'h10001, m_row});
        start_addr = 20'h82001;
        cyc(1, 0, 0, "R6 word after load");
        map_mode = 2; #1
        chk("R7 dword rotate", {mem_addr, row_scan}, {20'h08006, m_row});
        map_mode = 3; #1
        chk("R7 dword alt code", {mem_addr, row_scan}, {20'h08006, m_row});
        map_mode = 0; #1
        chk("R7 byte pass", {mem_addr, row_scan}, {20'h82001, m_row});

        // R8 bank substitution
        start_addr = 20'h00000; preset_row = 5'd3; max_scan = 5'd7;
        cyc(1, 0, 0, "R1 frame load");
        disp_active = 0; bank13_pass = 0; bank14_pass = 0; #1
        chk("R8 inactive no replace", {mem_addr, row_scan}, {20'h00000, 5'd3});
        disp_active = 1; #1
        chk("R8 both replaced", {mem_addr, row_scan}, {20'h06000, 5'd3});
        bank14_pass = 1; #1
        chk("R8 bit13 only", {mem_addr, row_scan}, {20'h02000, 5'd3});
        bank13_pass = 1; bank14_pass = 0; #1
        chk("R8 bit14 only", {mem_addr, row_scan}, {20'h04000, 5'd3});
        cyc(0, 1, 0, "R8 row 4 during display");
        bank14_pass = 1; disp_active = 0;

        // R9 split screen
        start_addr = 20'h05555; preset_row = 2; max_scan = 3; line_offset = 10'd9;
        line_cmp = 11'd100; line_num = 11'd99;
        cyc(1, 0, 0, "R1 frame load");
        cyc(0, 1, 0, "R9 no match");
        cyc(0, 0, 1, "R5 step");
        line_num = 11'd100;
        cyc(0, 1, 0, "R9 compare clear");
        chk("R9 explicit zero", {mem_addr, row_scan}, 25'd0);
        line_num = 11'd101;
        cyc(0, 1, 0, "R9 after split");
        for (int k = 0; k < 3; k++) cyc(0, 0, 1, "R9 step after split");

        // R10 priority
        start_addr = 20'h0ABCD; preset_row = 4;
        cyc(1, 1, 1, "R10 frame wins");
        chk("R10 frame explicit", {mem_addr, row_scan}, {20'h0ABCD, 5'd4});
        cyc(0, 0, 1, "R5 step");
        cyc(0, 1, 1, "R10 line wins");
        chk("R10 line explicit", {mem_addr, row_scan}, {20'h0ABCD, 5'd5});

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule